// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Skip Requests

This block is the 4-bit accumulator datapath of a small controller core. It runs one instruction per clock. The inputs are a datapath operation select, the raw opcode byte, an immediate nibble, the nibble currently addressed in data RAM and the low data-pointer nibble. The block updates its accumulator and its carry flip-flop.

Every condition the instruction set can test (carry-out, equality, bit state, counter wrap) comes out as a registered skip request. The sequencer uses that request to discard the next instruction, so the block never branches itself.

The block keeps the upper nibble of the previous cycle's opcode. A chain of load-immediate instructions that share the same upper opcode nibble therefore loads only its first member. Later members behave as no-ops. The two decimal adjusts have no condition: they are plain additions of 6 or 10 modulo 16.

Top module: `acc_alu4`

## Requirements
- R1: While rst_n is low, acc, carry and skip are 0 and the stored previous upper opcode nibble is 0. After reset, a load-immediate whose opcode upper nibble is 0 is therefore suppressed.
- R2: Load-immediate (op_sel 1) writes opcode[3:0] to acc only when opcode[7:4] differs from the opcode[7:4] presented in the previous cycle. Every cycle, whatever its op_sel, records its opcode upper nibble as the previous one.
- R3: Add (op_sel 2) sets acc to (acc + ram_nib) mod 16. It requests a skip exactly when the true sum exceeds 15, and it leaves carry unchanged.
- R4: Add-with-carry (op_sel 3) sets acc to (acc + ram_nib + carry) mod 16 and stores the carry-out in carry, with no skip. The skipping variant (op_sel 4) does the same and also requests a skip on carry-out.
- R5: The addition decimal adjust (op_sel 5) sets acc to (acc + 6) mod 16. The subtraction decimal adjust (op_sel 6) sets acc to (acc + 10) mod 16. Neither requests a skip.
- R6: Complement (op_sel 8) inverts all four acc bits. Negate (op_sel 9) inverts them and then adds 1 mod 16.
- R7: Exclusive-or (op_sel 7) sets acc to acc XOR ram_nib.
- R8: Increment (op_sel 13) adds 1 mod 16 and skips when the result is 0. Decrement (op_sel 14) subtracts 1 mod 16 and skips when the result is 15.
- R9: op_sel 10 clears carry and op_sel 11 sets it. op_sel 12 requests a skip when carry is 1 and changes neither acc nor carry.
- R10: The compares skip on equality and leave acc unchanged. op_sel 15 compares acc with imm, op_sel 16 compares acc with ram_nib, and op_sel 17 compares dpl with imm.
- R11: The bit tests take the bit index from opcode[1:0]. op_sel 18 skips when that acc bit is 1. op_sel 19 skips when that ram_nib bit is 1. op_sel 20 skips when that bit is equal in acc and ram_nib.
- R12: The skip output is registered and is valid in the cycle after the instruction. It is 0 after any instruction that does not request a skip. op_sel 0 and codes 21 to 31 change neither acc nor carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 5 | Datapath operation for this cycle |
| opcode | input | 8 | Raw opcode byte (bit index, chain detection, load value) |
| imm | input | 4 | Immediate nibble for compares |
| ram_nib | input | 4 | Addressed data RAM nibble |
| dpl | input | 4 | Low data-pointer nibble |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flip-flop |
| skip | output | 1 | Skip request for the next instruction |

## Verification
The hardest case to reach is the load-immediate chain rule. Whether a load takes effect depends on the opcode of the cycle before, and right after reset it also depends on the cleared history. The bench drives back-to-back loads with equal and with differing upper nibbles, and separates other loads with a no-op carrying a different upper nibble. It also issues a load with upper nibble 0 straight after reset and expects that load to be suppressed. The carry-out corners of the add-with-carry variants are reached by setting carry explicitly before each add.

// File: rtl/acc_alu4.sv
module acc_alu4 #(
  parameter int W   = 4,
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     op_sel,
  input  logic [OPW-1:0] opcode,
  input  logic [W-1:0]   imm,
  input  logic [W-1:0]   ram_nib,
  input  logic [W-1:0]   dpl,
  output logic [W-1:0]   acc,
  output logic           carry,
  output logic           skip
);
  localparam int BW = $clog2(W);
  localparam int HW = OPW / 2;

  localparam logic [4:0] K_NOP = 5'd0,  K_LDI = 5'd1,  K_ADD = 5'd2,  K_ADC = 5'd3,
                         K_ADCS = 5'd4, K_DAA = 5'd5,  K_DAS = 5'd6,  K_XOR = 5'd7,
                         K_CPL = 5'd8,  K_NEG = 5'd9,  K_CLRC = 5'd10, K_SETC = 5'd11,
                         K_TSTC = 5'd12, K_INC = 5'd13, K_DEC = 5'd14, K_CMPI = 5'd15,
                         K_CMPM = 5'd16, K_CMPD = 5'd17, K_BTA = 5'd18, K_BTM = 5'd19,
                         K_BTE = 5'd20;

  logic [HW-1:0] prev_hi;
  logic [W:0]    sum_plain, sum_c;
  logic [BW-1:0] bidx;
  logic          li_take;
  logic [W-1:0]  acc_n;
  logic          carry_n, skip_n;

  assign sum_plain = {1'b0, acc} + {1'b0, ram_nib};
  assign sum_c     = sum_plain + (W+1)'(carry);
  assign bidx      = opcode[BW-1:0];
  assign li_take   = prev_hi != opcode[OPW-1:HW];

  always_comb begin
    acc_n   = acc;
    carry_n = carry;
    skip_n  = 1'b0;
    case (op_sel)
      K_LDI:  if (li_take) acc_n = opcode[W-1:0];
      K_ADD:  begin acc_n = sum_plain[W-1:0]; skip_n = sum_plain[W]; end
      K_ADC:  begin acc_n = sum_c[W-1:0]; carry_n = sum_c[W]; end
      K_ADCS: begin acc_n = sum_c[W-1:0]; carry_n = sum_c[W]; skip_n = sum_c[W]; end
      K_DAA:  acc_n = acc + W'(6);
      K_DAS:  acc_n = acc + W'(10);
      K_XOR:  acc_n = acc ^ ram_nib;
      K_CPL:  acc_n = ~acc;
      K_NEG:  acc_n = ~acc + W'(1);
      K_CLRC: carry_n = 1'b0;
      K_SETC: carry_n = 1'b1;
      K_TSTC: skip_n = carry;
      K_INC:  begin acc_n = acc + W'(1); skip_n = (acc_n == '0); end
      K_DEC:  begin acc_n = acc - W'(1); skip_n = (acc_n == '1); end
      K_CMPI: skip_n = (acc == imm);
      K_CMPM: skip_n = (acc == ram_nib);
      K_CMPD: skip_n = (dpl == imm);
      K_BTA:  skip_n = acc[bidx];
      K_BTM:  skip_n = ram_nib[bidx];
      K_BTE:  skip_n = (acc[bidx] == ram_nib[bidx]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      carry   <= 1'b0;
      skip    <= 1'b0;
      prev_hi <= '0;
    end else begin
      acc     <= acc_n;
      carry   <= carry_n;
      skip    <= skip_n;
      prev_hi <= opcode[OPW-1:HW];
    end
  end

  // R2: a chain-breaking load lands its nibble
  p_li_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == K_LDI && li_take) |=> acc == $past(opcode[W-1:0]));
  // R3: plain add never touches carry
  p_add_keeps_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == K_ADD) |=> $stable(carry));
  // R8: increment skips exactly on wrap to zero
  p_inc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == K_INC) |=> skip == (acc == '0));
  // R9: set-carry takes effect next cycle
  p_setc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == K_SETC) |=> carry);
  // R12: no-op holds the state and drops the skip
  p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == K_NOP) |=> (!skip && $stable(acc) && $stable(carry)));
endmodule

// File: tb/tb_acc_alu4.sv
module tb_acc_alu4;
  logic clk = 0, rst_n = 0;
  logic [4:0] op_sel = 0;
  logic [7:0] opcode = 0;
  logic [3:0] imm = 0, ram_nib = 0, dpl = 0;
  logic [3:0] acc;
  logic carry, skip;
  int n_chk = 0, n_bad = 0;

  acc_alu4 dut (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opcode(opcode), .imm(imm),
                .ram_nib(ram_nib), .dpl(dpl), .acc(acc), .carry(carry), .skip(skip));

  always #10 clk = ~clk;

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [4:0] o, input logic [7:0] oc = 8'h00,
                     input logic [3:0] im = 0, input logic [3:0] rm = 0, input logic [3:0] dp = 0);
    @(negedge clk);
    op_sel = o; opcode = oc; imm = im; ram_nib = rm; dpl = dp;
    @(posedge clk); #1;
    @(negedge clk);
    op_sel = 0; opcode = 8'h00;
  endtask

  task automatic put(input logic [3:0] v);
    run(0, 8'h00);
    run(1, {4'h9, v});
  endtask

  task automatic t_reset;
    chk("R1 acc", acc, 0); chk("R1 carry", carry, 0); chk("R1 skip", skip, 0);
    run(1, 8'h05);
    chk("R1 suppressed load", acc, 0);
  endtask

  task automatic t_chain;
    run(0, 8'h00); run(1, 8'h93); chk("R2 first", acc, 3);
    @(negedge clk); op_sel = 1; opcode = 8'h97; @(posedge clk); #1;
    @(negedge clk); opcode = 8'h95; @(posedge clk); #1;
    chk("R2 chained", acc, 7);
    @(negedge clk); opcode = 8'hA2; @(posedge clk); #1;
    chk("R2 new upper", acc, 2);
    @(negedge clk); op_sel = 0; opcode = 8'h00;
  endtask

  task automatic t_add;
    run(11);
    put(9);  run(2, 8'h00, 0, 8); chk("R3 sum", acc, 1); chk("R3 skip", skip, 1); chk("R3 carry", carry, 1);
    put(3);  run(2, 8'h00, 0, 4); chk("R3 sum2", acc, 7); chk("R3 noskip", skip, 0);
    put(15); run(2, 8'h00, 0, 1); chk("R3 wrap", acc, 0); chk("R3 wrapskip", skip, 1);
  endtask

  task automatic t_adc;
    run(10); put(7); run(3, 8'h00, 0, 8);
    chk("R4 adc", acc, 15); chk("R4 adc c", carry, 0); chk("R4 adc s", skip, 0);
    run(11); put(7); run(3, 8'h00, 0, 8);
    chk("R4 adc ci", acc, 0); chk("R4 adc co", carry, 1); chk("R4 adc noskip", skip, 0);
    put(2); run(4, 8'h00, 0, 14);
    chk("R4 adcs", acc, 1); chk("R4 adcs c", carry, 1); chk("R4 adcs s", skip, 1);
    run(4, 8'h00, 0, 2);
    chk("R4 adcs2", acc, 4); chk("R4 adcs2 c", carry, 0); chk("R4 adcs2 s", skip, 0);
  endtask

  task automatic t_misc;
    put(12); run(5); chk("R5 daa", acc, 2); chk("R5 skip", skip, 0);
    put(9);  run(6); chk("R5 das", acc, 3);
    put(5);  run(8); chk("R6 cpl", acc, 10);
    put(5);  run(9); chk("R6 neg", acc, 11);
    put(0);  run(9); chk("R6 neg0", acc, 0);
    put(4'hA); run(7, 8'h00, 0, 6); chk("R7 xor", acc, 12);
  endtask

  task automatic t_incdec;
    put(15); run(13); chk("R8 inc wrap", acc, 0); chk("R8 inc skip", skip, 1);
    put(4);  run(13); chk("R8 inc", acc, 5); chk("R8 inc noskip", skip, 0);
    put(0);  run(14); chk("R8 dec wrap", acc, 15); chk("R8 dec skip", skip, 1);
    put(8);  run(14); chk("R8 dec", acc, 7); chk("R8 dec noskip", skip, 0);
  endtask

  task automatic t_carry;
    put(6);
    run(10); chk("R9 clr", carry, 0);
    run(12); chk("R9 test0", skip, 0);
    run(11); chk("R9 set", carry, 1);
    run(12); chk("R9 test1", skip, 1); chk("R9 acc kept", acc, 6); chk("R9 carry kept", carry, 1);
  endtask

  task automatic t_cmp;
    put(6);
    run(15, 8'h00, 6);  chk("R10 imm eq", skip, 1);
    run(15, 8'h00, 7);  chk("R10 imm ne", skip, 0);
    run(16, 8'h00, 0, 6); chk("R10 ram eq", skip, 1);
    run(16, 8'h00, 0, 5); chk("R10 ram ne", skip, 0);
    run(17, 8'h00, 11, 0, 11); chk("R10 dpl eq", skip, 1);
    run(17, 8'h00, 12, 0, 11); chk("R10 dpl ne", skip, 0);
    chk("R10 acc kept", acc, 6);
  endtask

  task automatic t_bits;
    put(4'b0100);
    run(18, 8'h02); chk("R11 acc b2", skip, 1);
    run(18, 8'h01); chk("R11 acc b1", skip, 0);
    run(19, 8'h03, 0, 4'b1000); chk("R11 ram b3", skip, 1);
    run(19, 8'h00, 0, 4'b1000); chk("R11 ram b0", skip, 0);
    run(20, 8'h02, 0, 4'b0110); chk("R11 eq b2", skip, 1);
    run(20, 8'h01, 0, 4'b0110); chk("R11 eq b1", skip, 0);
  endtask

  task automatic t_nop;
    put(15); run(13); chk("R12 pre skip", skip, 1);
    run(0, 8'h00, 0, 3); chk("R12 nop skip", skip, 0); chk("R12 nop acc", acc, 0);
    run(25, 8'h00, 0, 3); chk("R12 unused acc", acc, 0); chk("R12 unused skip", skip, 0);
    chk("R12 carry", carry, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_pre: begin chk("R1 acc in reset", acc, 0); end
    @(negedge clk); rst_n = 1;
    t_reset;
    t_chain;
    t_add;
    t_adc;
    t_misc;
    t_incdec;
    t_carry;
    t_cmp;
    t_bits;
    t_nop;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule